// File: doc/BRIEF.md
# Power-Up Strap Sampling Controller

Several pads on a clock generator serve two purposes: right after power comes up they are read as configuration inputs, and afterwards they drive clock outputs. External pull resistors set each pad high or low while the pad driver is off. This controller gates those drivers. When the supply-good indication rises, it keeps the drivers in high impedance for a fixed window, which is a parameter counted in reference clock cycles. During that window the resistors settle the pad levels. At the end of the window the controller captures the five configuration levels: four frequency-select bits and one mode bit. It then enables the drivers and raises a ready flag.

The captured values cannot be written. They are cleared only when supply-good drops, which stands for a power cycle. A later rise of supply-good starts a new, complete window and a new capture. Pad levels pass through a synchronizer before the capture, so the value kept is the one present on the pads a fixed number of cycles before the window closes.

Top module: `strap_sampler`

## Requirements
- R1: While `supplyGood` is low, `padOe`, `ready` and every bit of `strapLatched` are 0. The clear takes effect without waiting for a clock edge.
- R2: After `supplyGood` rises, `padOe` and `ready` stay 0 for exactly `WINDOW_CYCLES + 2` rising clock edges. The extra two edges are for supply-good synchronization. Both signals go to 1 together after that edge.
- R3: The capture stores a high pad as 1 and a low pad as 0. The bit mapping is: bit 0 is frequency select 0, bit 1 is select 1, bit 2 is select 2, bit 3 is select 3, and bit 4 is the mode bit.
- R4: The captured value is the pad level present at rising edge number `WINDOW_CYCLES` after `supplyGood` rises. A pad change that is first seen at a later edge has no effect on `strapLatched`.
- R5: A pad change during the window that is seen at or before edge `WINDOW_CYCLES` replaces the earlier level. The last level seen is the one kept.
- R6: Once `ready` is 1, `ready`, `padOe` and `strapLatched` keep their values for as long as `supplyGood` stays high, whatever the pads do.
- R7: After a fall and a new rise of `supplyGood`, the full window runs again and the straps are captured anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| supplyGood | input | 1 | Supply-good indication, low means power is absent |
| strapPin | input | 5 | Pad input levels: [3:0] frequency selects, [4] mode |
| padOe | output | 1 | Output enable for the dual-purpose pad drivers |
| strapLatched | output | 5 | Captured strap values, same bit order as `strapPin` |
| ready | output | 1 | Capture complete, clocks may run |

## Verification
Two things can land in the same cycle: a change on the pads, and the closing of the window that decides which level is kept. The bench moves the pads from one random pattern to another at a chosen edge near the end of the window, sweeping from a few edges before the sampling point to a few edges after it. The expected result is the new pattern when the change is seen at or before edge `WINDOW_CYCLES`, and the old pattern otherwise. The bench also confirms that `padOe` rises on exactly the expected edge in every case.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef struct packed {
    logic sample;
    logic enable;
  } strapStrobe_t;

  typedef enum logic {
    ST_WINDOW = 1'b0,
    ST_RUN    = 1'b1
  } strapState_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic         clk,
  input  logic         supplyGood,
  output logic         powerOk,
  output strapStrobe_t strobe
);
  localparam int CW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [1:0]    supplySync;
  logic [CW-1:0] count;
  strapState_t   state;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) supplySync <= '0;
    else             supplySync <= {supplySync[0], 1'b1};
  end
  assign powerOk = supplySync[1];

  always_ff @(posedge clk or negedge powerOk) begin
    if (!powerOk) begin
      count <= '0;
      state <= ST_WINDOW;
    end else if (state == ST_WINDOW) begin
      if (count == LAST) state <= ST_RUN;
      else               count <= count + 1'b1;
    end
  end

  always_comb begin
    strobe.sample = (state == ST_WINDOW) && (count == LAST);
    strobe.enable = (state == ST_RUN);
  end

  // R2: the counter never runs past the end of the window
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!powerOk)
    count <= LAST);
  // R2: the drivers turn on only right after the sampling strobe
  a_r2_enable_after_sample: assert property (@(posedge clk) disable iff (!powerOk)
    $rose(strobe.enable) |-> $past(strobe.sample));
  // R6: the run state holds while power stays good
  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!powerOk)
    strobe.enable |=> strobe.enable);
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int NUM_STRAPS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  powerOk,
  input  strapStrobe_t          strobe,
  input  logic [NUM_STRAPS-1:0] strapPin,
  output logic [NUM_STRAPS-1:0] strapLatched
);
  logic [NUM_STRAPS-1:0] syncQ [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge powerOk) begin
      if (!powerOk)    syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= strapPin;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge powerOk) begin
    if (!powerOk)          strapLatched <= '0;
    else if (strobe.sample) strapLatched <= syncQ[SYNC_STAGES-1];
  end

  // R4: without a sampling strobe the captured value cannot move
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!powerOk)
    !strobe.sample |=> $stable(strapLatched));
  // R3: a strobe captures the synchronized pad levels
  a_r3_latch_capture: assert property (@(posedge clk) disable iff (!powerOk)
    strobe.sample |=> strapLatched == $past(syncQ[SYNC_STAGES-1]));
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636,
  parameter int NUM_STRAPS    = 5
) (
  input  logic                  clk,
  input  logic                  supplyGood,
  input  logic [NUM_STRAPS-1:0] strapPin,
  output logic                  padOe,
  output logic [NUM_STRAPS-1:0] strapLatched,
  output logic                  ready
);
  logic         powerOk;
  strapStrobe_t strobe;

  strap_ctrl #(.WINDOW_CYCLES(WINDOW_CYCLES)) uCtrl (
    .clk(clk), .supplyGood(supplyGood), .powerOk(powerOk), .strobe(strobe)
  );

  strap_datapath #(.NUM_STRAPS(NUM_STRAPS), .SYNC_STAGES(2)) uData (
    .clk(clk), .powerOk(powerOk), .strobe(strobe),
    .strapPin(strapPin), .strapLatched(strapLatched)
  );

  assign padOe = strobe.enable;
  assign ready = strobe.enable;

  // R1: nothing is driven or reported before the window has ended
  a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!powerOk)
    !ready |-> (!padOe && strapLatched == '0) || $past(ready));
endmodule

// File: tb/tb_strap_sampler.sv
module tb_strap_sampler;
  localparam int W = 40;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         supplyGood = 1'b0;
  logic [N-1:0] strapPin = '0;
  logic         padOe, ready;
  logic [N-1:0] strapLatched;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  strap_sampler #(.WINDOW_CYCLES(W), .NUM_STRAPS(N)) dut (
    .clk(clk), .supplyGood(supplyGood), .strapPin(strapPin),
    .padOe(padOe), .strapLatched(strapLatched), .ready(ready)
  );

  function automatic logic [N-1:0] expectLatch(logic [N-1:0] a, logic [N-1:0] b, int n);
    return (n <= W - 1) ? b : a;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // raise supply with pattern a, switch to b after edge n; returns edge where padOe rose
  task automatic powerUp(logic [N-1:0] a, logic [N-1:0] b, int n);
    int riseEdge = -1;
    @(negedge clk);
    strapPin = a;
    supplyGood = 1'b1;
    for (int e = 1; e <= W + 8; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == n) strapPin = b;
      if (padOe && riseEdge < 0) riseEdge = e;
    end
    check("R2 window length", riseEdge, W + 2);
    check("R2 ready with padOe", ready, 1);
    check("R3/R4/R5 captured straps", strapLatched, expectLatch(a, b, n));
  endtask

  task automatic powerDown();
    @(negedge clk);
    supplyGood = 1'b0;
    #1;
    check("R1 padOe cleared", padOe, 0);
    check("R1 ready cleared", ready, 0);
    check("R1 straps cleared", strapLatched, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] a, b, hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset padOe", padOe, 0);
    check("R1 reset ready", ready, 0);
    check("R1 reset straps", strapLatched, 0);

    // R3: each bit alone, no change during window
    for (int i = 0; i < N; i++) begin
      powerUp(N'(1) << i, N'(1) << i, 0);
      powerDown();
    end
    // R5 boundary: change seen exactly at the sampling edge is kept
    powerUp(5'h0A, 5'h15, W - 1);
    powerDown();
    // R4 boundary: change one edge later is ignored
    powerUp(5'h0A, 5'h15, W);
    powerDown();

    // random sweep around the sampling point, R7 re-sampling each cycle
    for (int k = 0; k < 20; k++) begin
      a = N'($urandom);
      b = N'($urandom);
      powerUp(a, b, W - 6 + int'($urandom_range(0, 9)));
      hold = strapLatched;
      // R6: pads toggle after ready, state must hold
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        strapPin = N'($urandom);
      end
      repeat (3) @(negedge clk);
      check("R6 straps hold", strapLatched, hold);
      check("R6 padOe hold", padOe, 1);
      powerDown();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule